// File: doc/BRIEF.md
# Operand Forwarding Select Unit

This block picks where each operand of the execute stage comes from in a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It looks at the two source register numbers held in the decode/execute latch. It compares them against the destination register number and register-write flag of the instructions now in the memory stage and the writeback stage. From that it produces a 2-bit select for each ALU operand mux. Code 00 takes the register-file value. Code 10 takes the result held in the execute/memory latch, which is one instruction ahead. Code 01 takes the value held in the memory/writeback latch, which is two instructions ahead.

A second output steers the store-data input of data memory. It applies when a store sits in the memory stage and the instruction in writeback is a load that wrote the register being stored. In that case the writeback value replaces the stale store data. Every output is a pure combinational function of the latch fields. The register file, the ALU and the pipeline latches are outside the block.

Top module: `fwd_unit`

## Requirements
- R1: Operand A select is 10 when the execute/memory register-write flag is 1, its destination is non-zero, and that destination equals the operand A source number.
- R2: Operand B select follows the R1 rule against the operand B source number, and is decided independently of operand A.
- R3: An operand select is 01 when the memory/writeback register-write flag is 1, its destination is non-zero and equals that operand's source, and R1/R2 does not give 10 for that operand.
- R4: When both stages qualify for the same operand, the select is 10, so the newer result wins (a chain of three writes to one register takes the second write's value).
- R5: A destination of register 0 is never forwarded: with source 0, both operand selects are 00 whatever the flags are.
- R6: A stage whose register-write flag is 0 never forwards, even when the numbers match. Such a stage also does not block a qualified older stage, so the select is then 01.
- R7: With no condition met, a select is 00. The code 11 is never produced.
- R8: The store-data bypass output is 1 when the memory/writeback register-write flag is 1, the execute/memory memory-write flag is 1, the writeback destination equals the store's data source register, and that register is non-zero.
- R9: The store-data bypass output is 0 when any one of the R8 conditions fails.
- R10: The store-data bypass output and the operand selects are evaluated independently, so they can be active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_i | input | 5 | Operand A source register number in the decode/execute latch |
| ex_src_b_i | input | 5 | Operand B source register number in the decode/execute latch |
| mem_rd_i | input | 5 | Destination register number in the execute/memory latch |
| mem_rf_we_i | input | 1 | Register-write flag in the execute/memory latch |
| mem_dm_we_i | input | 1 | Memory-write (store) flag in the execute/memory latch |
| mem_st_src_i | input | 5 | Store-data source register number in the execute/memory latch |
| wb_rd_i | input | 5 | Destination register number in the memory/writeback latch |
| wb_rf_we_i | input | 1 | Register-write flag in the memory/writeback latch |
| fwd_a_o | output | 2 | Operand A select: 00 register file, 01 writeback, 10 execute/memory |
| fwd_b_o | output | 2 | Operand B select, same encoding |
| st_byp_o | output | 1 | 1 selects the writeback value as store data |

## Verification
Two functions can be active in the same cycle: the store-data bypass and the operand B forward from writeback. Both act when a load in writeback feeds the register that a store in memory writes out, and an execute-stage instruction also reads that same register. The bench drives exactly that set of latch fields. It expects st_byp_o at 1 and fwd_b_o at 01 together, and then removes one flag at a time to see each output drop on its own. An exhaustive sweep over a small register range compares all three outputs with a bench model written from the requirements.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
`timescale 1ns/1ps
module fwd_match #(
  parameter int REG_W = 5
) (
  input  logic             we_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] src_i,
  output logic             hit_o
);
  always_comb hit_o = we_i && (dst_i != '0) && (dst_i == src_i);
endmodule

// File: rtl/fwd_operand_sel.sv
`timescale 1ns/1ps
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] mem_dst_i,
  input  logic             wb_we_i,
  input  logic [REG_W-1:0] wb_dst_i,
  output logic [1:0]       sel_o
);
  logic mem_hit, wb_hit;

  fwd_match #(.REG_W(REG_W)) u_mem (
    .we_i(mem_we_i), .dst_i(mem_dst_i), .src_i(src_i), .hit_o(mem_hit));
  fwd_match #(.REG_W(REG_W)) u_wb (
    .we_i(wb_we_i), .dst_i(wb_dst_i), .src_i(src_i), .hit_o(wb_hit));

  // newer producer has priority
  always_comb begin
    if (mem_hit)     sel_o = SEL_MEM;
    else if (wb_hit) sel_o = SEL_WB;
    else             sel_o = SEL_RF;
  end

  always_comb begin
    assert_sel_legal_R7: assert (sel_o != 2'b11) else $error("illegal select");
    if (mem_we_i && mem_dst_i != '0 && mem_dst_i == src_i) begin
      assert_mem_fwd_R1: assert (sel_o == 2'b10) else $error("missed mem forward");
    end
    if (sel_o == 2'b01) begin
      assert_wb_fwd_R3: assert (wb_we_i && wb_dst_i == src_i && wb_dst_i != '0)
        else $error("bad wb forward");
      assert_newer_wins_R4: assert (!(mem_we_i && mem_dst_i == src_i && mem_dst_i != '0))
        else $error("older result chosen");
    end
    if (src_i == '0) begin
      assert_no_zero_R5: assert (sel_o == 2'b00) else $error("r0 forwarded");
    end
    if (!mem_we_i && !wb_we_i) begin
      assert_we_gate_R6: assert (sel_o == 2'b00) else $error("forward without write");
    end
  end
endmodule

// File: rtl/fwd_store_byp.sv
`timescale 1ns/1ps
module fwd_store_byp #(
  parameter int REG_W = 5
) (
  input  logic             wb_we_i,
  input  logic [REG_W-1:0] wb_dst_i,
  input  logic             st_we_i,
  input  logic [REG_W-1:0] st_src_i,
  output logic             byp_o
);
  logic hit;

  fwd_match #(.REG_W(REG_W)) u_cmp (
    .we_i(wb_we_i), .dst_i(wb_dst_i), .src_i(st_src_i), .hit_o(hit));

  always_comb byp_o = hit && st_we_i;

  always_comb begin
    if (byp_o) begin
      assert_st_byp_R8: assert (wb_we_i && st_we_i && wb_dst_i == st_src_i && st_src_i != '0)
        else $error("spurious store bypass");
    end
    if (!st_we_i || !wb_we_i || st_src_i == '0) begin
      assert_st_off_R9: assert (!byp_o) else $error("store bypass while disqualified");
    end
  end
endmodule

// File: rtl/fwd_unit.sv
`timescale 1ns/1ps
module fwd_unit #(
  parameter int REG_W  = 5,
  localparam int N_OPS = 2
) (
  input  logic [REG_W-1:0] ex_src_a_i,
  input  logic [REG_W-1:0] ex_src_b_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_rf_we_i,
  input  logic             mem_dm_we_i,
  input  logic [REG_W-1:0] mem_st_src_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_rf_we_i,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             st_byp_o
);
  logic [REG_W-1:0] src [N_OPS];
  logic [1:0]       sel [N_OPS];

  always_comb begin
    src[0] = ex_src_a_i;
    src[1] = ex_src_b_i;
  end

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    fwd_operand_sel #(.REG_W(REG_W)) u_sel (
      .src_i    (src[g]),
      .mem_we_i (mem_rf_we_i),
      .mem_dst_i(mem_rd_i),
      .wb_we_i  (wb_rf_we_i),
      .wb_dst_i (wb_rd_i),
      .sel_o    (sel[g])
    );
  end

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];

  fwd_store_byp #(.REG_W(REG_W)) u_st (
    .wb_we_i (wb_rf_we_i),
    .wb_dst_i(wb_rd_i),
    .st_we_i (mem_dm_we_i),
    .st_src_i(mem_st_src_i),
    .byp_o   (st_byp_o)
  );

  // operands are decided independently (R2, R10)
  always_comb begin
    if (ex_src_a_i == ex_src_b_i) begin
      assert_ops_same_R2: assert (fwd_a_o == fwd_b_o) else $error("operands disagree");
    end
  end
endmodule

// File: tb/sim_fwd_unit.sv
`timescale 1ns/1ps
module sim_fwd_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [4:0] src_a, src_b, m_rd, m_st, w_rd;
  logic       m_we, m_dw, w_we;
  logic [1:0] fa, fb;
  logic       sb;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  fwd_unit u0 (
    .ex_src_a_i(src_a), .ex_src_b_i(src_b), .mem_rd_i(m_rd), .mem_rf_we_i(m_we),
    .mem_dm_we_i(m_dw), .mem_st_src_i(m_st), .wb_rd_i(w_rd), .wb_rf_we_i(w_we),
    .fwd_a_o(fa), .fwd_b_o(fb), .st_byp_o(sb));

  task automatic drive(input logic [4:0] a, b, mrd, input logic mwe, mdw,
                       input logic [4:0] mst, wrd, input logic wwe);
    @(negedge clk);
    src_a = a; src_b = b; m_rd = mrd; m_we = mwe; m_dw = mdw;
    m_st = mst; w_rd = wrd; w_we = wwe;
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input logic [1:0] ea, eb, input logic es);
    n_chk++;
    if (fa !== ea || fb !== eb || sb !== es) begin
      n_fail++;
      $display("FAIL %s: got a=%b b=%b st=%b, expected a=%b b=%b st=%b",
               req, fa, fb, sb, ea, eb, es);
    end
  endtask

  function automatic logic [1:0] ref_sel(input logic [4:0] s, input logic mwe,
      input logic [4:0] mrd, input logic wwe, input logic [4:0] wrd);
    if (mwe && mrd != 0 && mrd == s) return 2'b10;
    if (wwe && wrd != 0 && wrd == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic t_idle;
    drive(0, 0, 0, 0, 0, 0, 0, 0); chk("R7 idle", 2'b00, 2'b00, 1'b0);
    drive(3, 4, 5, 1, 0, 0, 6, 1); chk("R7 no match", 2'b00, 2'b00, 1'b0);
  endtask

  task automatic t_mem_fwd;
    drive(7, 2, 7, 1, 0, 0, 0, 0); chk("R1 A from mem", 2'b10, 2'b00, 1'b0);
    drive(2, 7, 7, 1, 0, 0, 0, 0); chk("R2 B from mem", 2'b00, 2'b10, 1'b0);
    drive(9, 9, 9, 1, 0, 0, 0, 0); chk("R2 both from mem", 2'b10, 2'b10, 1'b0);
  endtask

  task automatic t_wb_fwd;
    drive(12, 3, 0, 0, 0, 0, 12, 1); chk("R3 A from wb", 2'b01, 2'b00, 1'b0);
    drive(3, 31, 1, 1, 0, 0, 31, 1); chk("R3 B from wb", 2'b00, 2'b01, 1'b0);
  endtask

  task automatic t_newer;
    drive(1, 4, 1, 1, 0, 0, 1, 1); chk("R4 chain same reg", 2'b10, 2'b00, 1'b0);
    drive(4, 2, 4, 1, 0, 0, 2, 1); chk("R4 split stages", 2'b10, 2'b01, 1'b0);
  endtask

  task automatic t_zero;
    drive(0, 0, 0, 1, 0, 0, 0, 1); chk("R5 r0 both stages", 2'b00, 2'b00, 1'b0);
    drive(0, 5, 0, 1, 0, 0, 5, 1); chk("R5 r0 A only", 2'b00, 2'b01, 1'b0);
  endtask

  task automatic t_we_clear;
    drive(6, 6, 6, 0, 0, 0, 6, 0); chk("R6 no write flags", 2'b00, 2'b00, 1'b0);
    drive(6, 8, 6, 0, 0, 0, 6, 1); chk("R6 mem idle, wb wins", 2'b01, 2'b00, 1'b0);
  endtask

  task automatic t_store;
    drive(0, 0, 0, 0, 1, 5, 5, 1); chk("R8 load to store", 2'b00, 2'b00, 1'b1);
    drive(0, 0, 0, 0, 0, 5, 5, 1); chk("R9 no mem write", 2'b00, 2'b00, 1'b0);
    drive(0, 0, 0, 0, 1, 5, 5, 0); chk("R9 no reg write", 2'b00, 2'b00, 1'b0);
    drive(0, 0, 0, 0, 1, 5, 6, 1); chk("R9 reg mismatch", 2'b00, 2'b00, 1'b0);
    drive(0, 0, 0, 0, 1, 0, 0, 1); chk("R9 reg zero", 2'b00, 2'b00, 1'b0);
  endtask

  task automatic t_overlap;
    drive(3, 10, 0, 0, 1, 10, 10, 1); chk("R10 store and B together", 2'b00, 2'b01, 1'b1);
    drive(3, 10, 0, 0, 0, 10, 10, 1); chk("R10 store drops alone", 2'b00, 2'b01, 1'b0);
    drive(3, 11, 0, 0, 1, 10, 10, 1); chk("R10 B drops alone", 2'b00, 2'b00, 1'b1);
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 4096; k++) begin
      logic [4:0] a, b, mrd, mst, wrd;
      logic mwe, mdw, wwe;
      a = 5'(k[1:0]); b = 5'(k[3:2]); mrd = 5'(k[5:4]); wrd = 5'(k[7:6]);
      mst = 5'(k[9:8]); mwe = k[10]; wwe = k[11]; mdw = k[0] ^ k[11];
      drive(a, b, mrd, mwe, mdw, mst, wrd, wwe);
      chk("R1 R3 R4 R8 sweep", ref_sel(a, mwe, mrd, wwe, wrd), ref_sel(b, mwe, mrd, wwe, wrd),
          wwe && mdw && wrd == mst && mst != 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_mem_fwd();
    t_wb_fwd();
    t_newer();
    t_zero();
    t_we_clear();
    t_store();
    t_overlap();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule